// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This peripheral watches for a stalled processor. A down-counter runs while the watchdog is enabled. When it reaches zero it reloads from a programmed period and records a warning in an interrupt status bit. If a second expiry arrives before software has cleared that warning, the block pulses a system reset output. Software keeps the system alive by rewriting the period register, which also restarts the count. It acknowledges the warning by writing the clear register.

Every configuration register is guarded by a key register. Writes to the period, control and clear registers only take effect while the key register holds the unlock value. The key register itself always accepts writes, and any value other than the key closes the guard again. Accesses use a small word-addressed register bus. A write completes on the clock edge where it is presented, and read data is combinational on the address.

A sequencer with three states shapes the reset output. `S_HALT` is entered while the enable bit is clear. `S_RUN` is the normal counting state. `S_BITE` lasts for each cycle in which the reset output is high. The transitions are:
- any state to `S_BITE` in the cycle after a second, uncleared expiry with reset enabled;
- any state to `S_HALT` when enable is clear and no bite is pending;
- otherwise, any state to `S_RUN` while enable is set.

Top module: `twdt_top`

## Requirements
- R1: After reset the period register reads all ones, control reads 0, status reads 0 and the key register reads 1 (locked). `wdt_irq` and `wdt_rst` are low.
- R2: Writing 0x1ACCE551 to offset 4 unlocks, and offset 4 then reads 0. Writing any other value there locks, and it then reads 1. Writes to offset 4 are accepted whether locked or not.
- R3: While locked, writes to offsets 0, 1 and 3 change nothing: not the register contents, the counter, the status or the outputs.
- R4: An accepted write to offset 0 stores the value as the period and loads it into the counter. In that cycle no expiry takes place, whatever the counter held.
- R5: Control is at offset 1. Bit 0 enables counting and the interrupt, and bit 1 enables reset. While bit 0 is clear the counter holds its value and no expiry occurs.
- R6: While enabled, the counter decrements once per cycle. An expiry is the cycle in which it holds zero, and in that cycle it reloads from the period register. Expiries are therefore period+1 cycles apart.
- R7: An expiry sets the status bit, which reads as bit 0 of offset 2. From the next cycle, `wdt_irq` equals the status bit ANDed with control bit 0.
- R8: The status bit reads back at offset 2 even while control bit 0 is clear, and `wdt_irq` is low in that case.
- R9: An expiry that finds the status bit already set, with control bit 1 set and no clear in the same cycle, drives `wdt_rst` high for the following cycle. Expiries with bit 1 clear never raise `wdt_rst`.
- R10: Any accepted write to offset 3 clears the status bit. If it coincides with an expiry, the status bit ends set and no reset pulse follows.
- R11: Offset 3 and offsets 5 to 7 read 0. Control reads 0 above bit 1. Read data is 0 unless `bus_sel` is high and `bus_wr` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| wdt_irq | output | 1 | Warning interrupt level |
| wdt_rst | output | 1 | System reset pulse |

## Verification
Two collisions can happen in a single cycle: an expiry together with a status-clear write, and an expiry together with a period write. The bench creates each one on purpose. It uses its own cycle model to find the cycle in which the counter holds zero, then issues the write in exactly that cycle. For the first collision, the status bit must read 1 afterwards and `wdt_rst` must stay low. For the second, no interrupt may appear and the count must restart from the written value. The random phase also produces both collisions, and each result is compared against the model cycle by cycle.

// File: rtl/twdt_pkg.sv
package twdt_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFF_LOAD = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_RIS  = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_ICR  = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_LOCK = 3'd4;

    localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

    typedef enum logic [1:0] {
        S_HALT = 2'd0,
        S_RUN  = 2'd1,
        S_BITE = 2'd2
    } wdt_state_e;
endpackage

// File: rtl/twdt_regs.sv
module twdt_regs
    import twdt_pkg::*;
#(
    parameter int LOAD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              ris,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [LOAD_W-1:0] load_q,
    output logic [1:0]        ctrl_q,
    output logic              load_wr,
    output logic              icr_clr,
    output logic              unlocked
);
    logic wr_any;
    logic wr_ok;

    assign wr_any  = bus_sel && bus_wr;
    assign wr_ok   = wr_any && unlocked;
    assign load_wr = wr_ok && (bus_addr == OFF_LOAD);
    assign icr_clr = wr_ok && (bus_addr == OFF_ICR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            load_q   <= '1;
            ctrl_q   <= 2'b00;
        end else begin
            if (wr_any && (bus_addr == OFF_LOCK))
                unlocked <= (bus_wdata == UNLOCK_KEY);
            if (load_wr)
                load_q <= bus_wdata[LOAD_W-1:0];
            if (wr_ok && (bus_addr == OFF_CTRL))
                ctrl_q <= bus_wdata[1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFF_LOAD: bus_rdata[LOAD_W-1:0] = load_q;
                OFF_CTRL: bus_rdata[1:0]        = ctrl_q;
                OFF_RIS:  bus_rdata[0]          = ris;
                OFF_LOCK: bus_rdata[0]          = !unlocked;
                default:  bus_rdata             = '0;
            endcase
        end
    end
endmodule

// File: rtl/twdt_counter.sv
module twdt_counter #(
    parameter int LOAD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              load_wr,
    input  logic [LOAD_W-1:0] load_val,
    input  logic [LOAD_W-1:0] load_q,
    output logic [LOAD_W-1:0] cnt,
    output logic              expire
);
    logic at_zero;

    assign at_zero = (cnt == '0);
    assign expire  = run_en && at_zero && !load_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '1;
        else if (load_wr)
            cnt <= load_val;
        else if (run_en)
            cnt <= at_zero ? load_q : cnt - 1'b1;
    end
endmodule

// File: rtl/twdt_fsm.sv
module twdt_fsm
    import twdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic rst_en,
    input  logic expire,
    input  logic icr_clr,
    output logic ris,
    output logic wdt_irq,
    output logic wdt_rst
);
    wdt_state_e state_q, state_d;
    logic       bite;

    assign bite = expire && ris && !icr_clr && rst_en;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HALT:  state_d = bite ? S_BITE : (run_en ? S_RUN : S_HALT);
            S_RUN:   state_d = bite ? S_BITE : (run_en ? S_RUN : S_HALT);
            S_BITE:  state_d = bite ? S_BITE : (run_en ? S_RUN : S_HALT);
            default: state_d = S_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_HALT;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ris <= 1'b0;
        else if (expire)
            ris <= 1'b1;
        else if (icr_clr)
            ris <= 1'b0;
    end

    always_comb begin
        wdt_rst = (state_q == S_BITE);
        wdt_irq = ris && run_en;
    end
endmodule

// File: rtl/twdt_top.sv
module twdt_top
    import twdt_pkg::*;
#(
    parameter int LOAD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              wdt_irq,
    output logic              wdt_rst
);
    logic [LOAD_W-1:0] load_q;
    logic [LOAD_W-1:0] cnt;
    logic [1:0]        ctrl_q;
    logic              load_wr;
    logic              icr_clr;
    logic              unlocked;
    logic              expire;
    logic              ris;

    twdt_regs #(.LOAD_W(LOAD_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ris(ris), .bus_rdata(bus_rdata),
        .load_q(load_q), .ctrl_q(ctrl_q), .load_wr(load_wr),
        .icr_clr(icr_clr), .unlocked(unlocked)
    );

    twdt_counter #(.LOAD_W(LOAD_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .run_en(ctrl_q[0]),
        .load_wr(load_wr), .load_val(bus_wdata[LOAD_W-1:0]),
        .load_q(load_q), .cnt(cnt), .expire(expire)
    );

    twdt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .run_en(ctrl_q[0]), .rst_en(ctrl_q[1]),
        .expire(expire), .icr_clr(icr_clr), .ris(ris),
        .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
    );
endmodule

// File: rtl/twdt_checker.sv
module twdt_checker
    import twdt_pkg::*;
#(
    parameter int LOAD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              unlocked,
    input logic [1:0]        ctrl_q,
    input logic              ris,
    input logic              expire,
    input logic [LOAD_W-1:0] cnt,
    input logic [LOAD_W-1:0] load_q,
    input logic              load_wr,
    input logic              icr_clr,
    input logic              wdt_rst
);
    p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFF_LOCK && bus_wdata == UNLOCK_KEY) |=> unlocked);

    p_lock_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && bus_sel && bus_wr && bus_addr != OFF_LOCK)
            |=> ($stable(ctrl_q) && $stable(load_q)));

    p_halt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[0] && !load_wr) |=> $stable(cnt));

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt == $past(load_q)));

    p_ris_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> ris);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (icr_clr && !expire) |=> !ris);

    p_bite_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> $past(expire && ris && ctrl_q[1] && !icr_clr));
endmodule

bind twdt_top twdt_checker #(.LOAD_W(LOAD_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .unlocked(unlocked),
    .ctrl_q(ctrl_q), .ris(ris), .expire(expire), .cnt(cnt),
    .load_q(load_q), .load_wr(load_wr), .icr_clr(icr_clr), .wdt_rst(wdt_rst)
);

// File: tb/twdt_top_bench.sv
module twdt_top_bench;
    localparam logic [31:0] KEY = 32'h1ACC_E551;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_irq;
    logic        wdt_rst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // bench-side model state
    logic [31:0] m_load, m_cnt;
    logic [1:0]  m_ctrl;
    logic        m_ris, m_unl, m_rst;

    twdt_top u_twdt_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:    return m_load;
            3'd1:    return {30'b0, m_ctrl};
            3'd2:    return {31'b0, m_ris};
            3'd4:    return {31'b0, !m_unl};
            default: return 32'b0;
        endcase
    endfunction

    function automatic string read_tag(input logic [2:0] a);
        case (a)
            3'd0:    return "R4";
            3'd1:    return "R5";
            3'd2:    return "R8";
            3'd4:    return "R2";
            default: return "R11";
        endcase
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks = checks + 1;
        if (act !== expv) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // one bus cycle: drive at negedge, check, advance model across posedge
    task automatic cyc(input logic s, input logic w, input logic [2:0] a,
                       input logic [31:0] d, input string tag);
        logic wr_ok, ld, clr, ex, bite;
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        check32("R7", {31'b0, wdt_irq}, {31'b0, m_ris && m_ctrl[0]});
        check32("R9", {31'b0, wdt_rst}, {31'b0, m_rst});
        if (s && !w)
            check32((tag == "") ? read_tag(a) : tag, bus_rdata, exp_read(a));
        else
            check32("R11", bus_rdata, 32'b0);
        wr_ok = s && w && m_unl;
        ld    = wr_ok && a == 3'd0;
        clr   = wr_ok && a == 3'd3;
        ex    = m_ctrl[0] && m_cnt == 0 && !ld;
        bite  = ex && m_ris && !clr && m_ctrl[1];
        m_rst = bite;
        m_ris = ex ? 1'b1 : (clr ? 1'b0 : m_ris);
        if (ld) m_cnt = d;
        else if (m_ctrl[0]) m_cnt = (m_cnt == 0) ? m_load : m_cnt - 1;
        if (ld) m_load = d;
        if (wr_ok && a == 3'd1) m_ctrl = d[1:0];
        if (s && w && a == 3'd4) m_unl = (d == KEY);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'd0, 32'd0, "");
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b1, a, d, "");
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        cyc(1'b1, 1'b0, a, 32'd0, tag);
    endtask

    initial begin
        void'($urandom(32'd4242));
        m_load = '1; m_cnt = '1; m_ctrl = 2'b00; m_ris = 1'b0; m_unl = 1'b0; m_rst = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) rd(3'(a), "R1");

        // R3 locked writes ignored
        wr(3'd1, 32'd3);
        wr(3'd0, 32'd5);
        wr(3'd3, 32'd1);
        rd(3'd1, "R3");
        rd(3'd0, "R3");

        // R2 unlock
        wr(3'd4, KEY);
        rd(3'd4, "R2");

        // R6/R7/R9 warn then bite
        wr(3'd0, 32'd4);
        wr(3'd1, 32'd3);
        idle(12);
        rd(3'd2, "R7");

        // R10 clear
        wr(3'd3, 32'd0);
        rd(3'd2, "R10");

        // R10 clear in the same cycle as a second expiry
        while (!(m_ris && m_cnt == 0)) idle(1);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd2, "R10");
        idle(3);

        // R4 period write on the expiry cycle cancels it
        wr(3'd3, 32'd0);
        while (m_cnt != 0) idle(1);
        wr(3'd0, 32'd7);
        rd(3'd2, "R4");
        idle(10);

        // R8 halted: status still visible, no irq
        wr(3'd1, 32'd2);
        rd(3'd2, "R8");
        idle(10);

        // R9 reset disabled: interrupt only
        wr(3'd1, 32'd1);
        idle(30);

        // R2/R3 relock and ignored write
        wr(3'd4, 32'hDEAD_DEAD);
        rd(3'd4, "R2");
        wr(3'd1, 32'd0);
        rd(3'd1, "R3");
        rd(3'd6, "R11");

        // random phase
        wr(3'd4, KEY);
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = $urandom_range(0, 99);
            if (r < 60)      idle(1);
            else if (r < 68) wr(3'd0, 32'($urandom_range(0, 15)));
            else if (r < 74) wr(3'd1, 32'($urandom_range(0, 3)));
            else if (r < 82) wr(3'd3, $urandom);
            else if (r < 85) wr(3'd4, ($urandom_range(0, 3) == 0) ? $urandom : KEY);
            else if (r < 88) wr(3'($urandom_range(0, 7)), $urandom);
            else             rd(3'($urandom_range(0, 7)), "");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule